// File: doc/BRIEF.md
# Stream Rate Decimator

This stage sits between a 16-bit streaming source and its sink, for example after a converter input or before a converter output. It slows the stream by a programmable factor. The data word is never stored. It passes straight through. The block instead opens both handshake directions together for one clock cycle out of every `ratio_i` cycles. In all other cycles it forces the downstream valid and the upstream ready low.

A free-running pacing counter creates the open cycles (the slots). It does not count transfers. A slot that no transfer uses is lost, and the source is held off until the next slot. Nothing is discarded. A ratio of 0 or 1 makes the stage fully transparent. The ratio can be changed while the block runs, and each instance has its own ratio.

Top module: `stream_dec`

## Requirements
- R1: `out_data_o` equals `in_data_i` in every cycle, with no register in the path.
- R2: In a slot cycle `out_valid_o` equals `in_valid_i`. In every other cycle `out_valid_o` is 0.
- R3: In a slot cycle `in_ready_o` equals `out_ready_i`. In every other cycle `in_ready_o` is 0.
- R4: While `ratio_i` holds a value N >= 2, consecutive slots are exactly N clock cycles apart, with N-1 closed cycles between them.
- R5: While `ratio_i` is 0 or 1, every cycle is a slot.
- R6: While `rst_ni` is low the gate is open. The cycle ending at the first rising clock edge after `rst_ni` rises is a slot.
- R7: The slot positions do not depend on `in_valid_i` or `out_ready_i`. A slot with no transfer is not carried over to a later cycle.
- R8: Suppose the ratio is lowered to M while k cycles have passed since the last slot, with k >= M-1. Then the next cycle is a slot, and slots then recur every M cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | RATIO_W (32) | Decimation factor; 0 and 1 mean pass every cycle |
| in_data_i | input | DATA_W (16) | Upstream data word |
| in_valid_i | input | 1 | Upstream valid |
| in_ready_o | output | 1 | Ready returned to the upstream source |
| out_data_o | output | DATA_W (16) | Downstream data word |
| out_valid_o | output | 1 | Valid presented to the downstream sink |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The hardest case to reach from the ports is a ratio reduced in mid-period, where the hidden counter already sits past the new wrap point. The bench programs a ratio of 8 and lets five cycles pass after a slot. It then writes 3 and checks that the gate stays shut for the current cycle and opens at the next one, then every third cycle. Apart from this case, every ratio from 0 to 9 is swept after a fresh reset. First both handshake inputs are held high to measure the slot spacing. Then valid and ready follow arithmetic patterns, to show that slot placement ignores them.

// File: rtl/stream_dec_pkg.sv
package stream_dec_pkg;
  localparam int unsigned DATA_W_DEF  = 16;
  localparam int unsigned RATIO_W_DEF = 32;
endpackage

// File: rtl/stream_dec_pacer.sv
module stream_dec_pacer #(
  parameter int unsigned RATIO_W = stream_dec_pkg::RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               slot_o
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q;
  logic               bypass, wrap;

  assign bypass = (ratio_i <= ONE);
  // >= rather than == so a ratio lowered below the count wraps at once
  assign wrap   = bypass || (cnt_q >= ratio_i - ONE);
  assign slot_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + ONE;
  end

  AST_CNT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && cnt_q >= ratio_i - ONE) |=> slot_o); // R8
  AST_CNT_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && cnt_q < ratio_i - ONE) |=> (cnt_q == $past(cnt_q) + ONE)); // R4
  AST_BYPASS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> slot_o); // R5
endmodule

// File: rtl/stream_dec_gate.sv
module stream_dec_gate #(
  parameter int unsigned DATA_W = stream_dec_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i
);
  assign dn_data_o  = up_data_i;
  assign dn_valid_o = up_valid_i & slot_i;
  assign up_ready_o = dn_ready_i & slot_i;

  AST_VALID_SOURCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> up_valid_i); // R2
  AST_READY_SOURCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ready_o |-> dn_ready_i); // R3
endmodule

// File: rtl/stream_dec.sv
module stream_dec #(
  parameter int unsigned DATA_W  = stream_dec_pkg::DATA_W_DEF,
  parameter int unsigned RATIO_W = stream_dec_pkg::RATIO_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [DATA_W-1:0]  in_data_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  output logic [DATA_W-1:0]  out_data_o,
  output logic               out_valid_o,
  input  logic               out_ready_i
);
  logic slot;

  stream_dec_pacer #(.RATIO_W(RATIO_W)) i_pacer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ratio_i(ratio_i),
    .slot_o (slot)
  );

  stream_dec_gate #(.DATA_W(DATA_W)) i_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .slot_i    (slot),
    .up_data_i (in_data_i),
    .up_valid_i(in_valid_i),
    .up_ready_o(in_ready_o),
    .dn_data_o (out_data_o),
    .dn_valid_o(out_valid_o),
    .dn_ready_i(out_ready_i)
  );

  // both directions open in the same cycles
  AST_SIDES_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && out_ready_i) |-> (out_valid_o == in_ready_o)); // R7
  AST_DATA_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o == in_data_i)); // R1
endmodule

// File: tb/test_stream_dec.sv
module test_stream_dec;
  localparam int unsigned DW = 16;
  localparam int unsigned RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ratio = '0;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int mpos = 0;   // model: cycles since last slot

  always #10 clk = ~clk;

  stream_dec #(.DATA_W(DW), .RATIO_W(RW)) i_stream_dec (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  // spec model of slot position (R4, R5, R8)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mpos <= 0;
    else if (ratio <= 1) mpos <= 0;
    else if (mpos >= int'(ratio) - 1) mpos <= 0;
    else mpos <= mpos + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic drive(input logic v, input logic r, input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = v; out_ready = r; in_data = d;
    #2;
  endtask

  // compare every output against the model
  task automatic check_all(input string req);
    bit open;
    open = (mpos == 0);
    check({req, "/R1 data"}, int'(out_data), int'(in_data));
    check({req, "/R2 valid"}, int'(out_valid), int'(in_valid & open));
    check({req, "/R3 ready"}, int'(in_ready), int'(out_ready & open));
  endtask

  task automatic do_reset(input int r);
    @(negedge clk);
    rst_n = 1'b0; ratio = RW'(r);
    in_valid = 1'b1; out_ready = 1'b1; in_data = 16'h5a5a;
    #2;
    check("R6 open in reset valid", int'(out_valid), 1);
    check("R6 open in reset ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R6 first cycle open valid", int'(out_valid), 1);
    check("R6 first cycle open ready", int'(in_ready), 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    for (int r = 0; r < 10; r++) begin
      int n, last, gap_exp;
      n = (r <= 1) ? 1 : r;
      do_reset(r);
      // phase A: both sides willing, measure slot spacing (R4, R5)
      last = 0;
      for (int i = 1; i <= 3 * n + 2; i++) begin
        drive(1'b1, 1'b1, DW'(i * 97 + r));
        check_all(r <= 1 ? "R5" : "R4");
        if (in_ready) begin
          gap_exp = n;
          check(r <= 1 ? "R5 gap" : "R4 gap", i - last, gap_exp);
          last = i;
        end
      end
      // phase B: handshake patterns must not move slots (R7)
      for (int i = 0; i < 4 * n + 6; i++) begin
        drive(((i * 5 + r) % 3) != 0, ((i * 3 + r) % 4) != 1, DW'(i * 37 + r * 11));
        check_all("R7");
      end
    end

    // runtime ratio reduction (R8)
    do_reset(8);
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 1'b1, DW'(i));
      check_all("R8 pre");
    end
    @(negedge clk);
    ratio = 3;
    #2;
    check("R8 still closed", int'(in_ready), 0);
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, 1'b1, DW'(100 + i));
      check("R8 new spacing", int'(in_ready), int'((i % 3) == 0));
      check_all("R8");
    end

    finish_up();
  end
endmodule